// File: doc/BRIEF.md
# Pin change interrupt controller

This block watches twelve input pins and raises an interrupt when any selected pin toggles. The pins form two groups: a lower group of eight (pins 7:0) and an upper group of four (pins 11:8). Every pin has its own mask bit. Every group has one enable bit, one sticky event flag and one interrupt request line. A rising or a falling transition on any unmasked pin latches that group's flag. The request line is driven while the flag, the group enable and the global interrupt-enable input are all high.

Software reaches the block over a byte-wide register port. The port has an address, write data, a write strobe and a combinational read-data output. A flag is cleared by writing a one to it, or by an acknowledge pulse that the interrupt dispatch logic raises when it services that group. Pin inputs are asynchronous and pass through a two-stage synchronizer before edge detection.

Top module: `pcint_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and both interrupt request outputs are low.
- R2: Register map. Offset 0x0F holds the lower-group masks, all eight bits, bit n for pin n. Offset 0x10 holds the upper-group masks in bits 3:0, pin 8 in bit 0 through pin 11 in bit 3. Offset 0x11 holds the flags, lower group in bit 0 and upper group in bit 1. Offset 0x12 holds the group enables, lower group in bit 0 and upper group in bit 1. Unimplemented bits read 0 and ignore writes. Any other offset reads 0x00.
- R3: A rising or falling transition on a pin whose mask bit is 1 sets its group's flag. The flag reads set by the fourth clock edge after the pin changes.
- R4: A transition on a pin whose mask bit is 0 leaves the flag unchanged.
- R5: The flag sets even while the group enable bit is 0, so software can poll it.
- R6: irq_o[g] is high exactly when flag g, enable bit g and gie_i are all 1.
- R7: Writing a 1 to a flag bit at offset 0x11 clears that flag. Writing a 0 to a flag bit leaves it unchanged.
- R8: A one-cycle pulse on ack_i[g] clears flag g and leaves the other group's flag unchanged.
- R9: If a new event arrives in the same cycle as a clear, by write or by acknowledge, the flag stays set.
- R10: A transition in one group never sets the other group's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pins_i | input | 12 | Asynchronous pin inputs |
| ack_i | input | 2 | Per-group service acknowledge pulse |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 2 | Per-group interrupt request |

## Verification
Edge detection is tested with both rising and falling toggles on unmasked lower-group pins. These are compared with toggles on masked pins in both groups, including an upper-group pin next to an unmasked one, which tells mask decoding apart from group decoding. Toggles in the upper group alone check that the groups stay separate. The request line is swept over all combinations of enable and global bit with the flag set. A clear is timed to land on the exact cycle an event is detected, once by acknowledge and once by write, which tells set-priority apart from clear-priority.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  localparam int unsigned NGRP         = 2;
  localparam int unsigned OFS_MASK_LO  = 'h0F;
  localparam int unsigned OFS_MASK_HI  = 'h10;
  localparam int unsigned OFS_FLAG     = 'h11;
  localparam int unsigned OFS_CTRL     = 'h12;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  // toggle in either direction
  assign chg_o = s2_q ^ prev_q;
endmodule

// File: rtl/pcint_group.sv
module pcint_group #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] chg_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         gie_i,
  output logic         flag_o,
  output logic         irq_o
);
  logic hit;
  logic flag_q;

  assign hit = |(chg_i & mask_i);

  // a new event beats a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i & gie_i;

  AST_HIT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_o); // R3
  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && clr_i) |=> flag_o); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !flag_o); // R7
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !hit) |=> !flag_o); // R4
endmodule

// File: rtl/pcint_ctrl.sv
module pcint_ctrl
  import pcint_pkg::*;
#(
  parameter int unsigned LO_W = 8,
  parameter int unsigned HI_W = 4,
  parameter int unsigned AW   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 we_i,
  output logic [7:0]           rdata_o,
  input  logic [LO_W+HI_W-1:0] pins_i,
  input  logic [NGRP-1:0]      ack_i,
  input  logic                 gie_i,
  output logic [NGRP-1:0]      irq_o
);
  localparam int unsigned NPIN = LO_W + HI_W;

  logic [NPIN-1:0] chg;
  logic [LO_W-1:0] mask_lo_q;
  logic [HI_W-1:0] mask_hi_q;
  logic [NPIN-1:0] mask_all;
  logic [NGRP-1:0] en_q;
  logic [NGRP-1:0] flag;
  logic [NGRP-1:0] clr;
  logic            sel_mlo, sel_mhi, sel_flag, sel_ctrl;

  assign sel_mlo  = (addr_i == AW'(OFS_MASK_LO));
  assign sel_mhi  = (addr_i == AW'(OFS_MASK_HI));
  assign sel_flag = (addr_i == AW'(OFS_FLAG));
  assign sel_ctrl = (addr_i == AW'(OFS_CTRL));

  pcint_sync #(.W(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pins_i),
    .chg_o (chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_lo_q <= '0;
      mask_hi_q <= '0;
      en_q      <= '0;
    end else if (we_i) begin
      if (sel_mlo)  mask_lo_q <= wdata_i[LO_W-1:0];
      if (sel_mhi)  mask_hi_q <= wdata_i[HI_W-1:0];
      if (sel_ctrl) en_q      <= wdata_i[NGRP-1:0];
    end
  end

  assign mask_all = {mask_hi_q, mask_lo_q};
  assign clr      = ack_i | ({NGRP{we_i & sel_flag}} & wdata_i[NGRP-1:0]);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned GW = (g == 0) ? LO_W : HI_W;
    localparam int unsigned GB = (g == 0) ? 0 : LO_W;

    pcint_group #(.W(GW)) u_grp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .chg_i (chg[GB +: GW]),
      .mask_i(mask_all[GB +: GW]),
      .clr_i (clr[g]),
      .en_i  (en_q[g]),
      .gie_i (gie_i),
      .flag_o(flag[g]),
      .irq_o (irq_o[g])
    );

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[g] |-> (en_q[g] && flag[g])); // R6
  end

  always_comb begin
    rdata_o = 8'h00;
    if (sel_mlo)  rdata_o[LO_W-1:0] = mask_lo_q;
    if (sel_mhi)  rdata_o[HI_W-1:0] = mask_hi_q;
    if (sel_flag) rdata_o[NGRP-1:0] = flag;
    if (sel_ctrl) rdata_o[NGRP-1:0] = en_q;
  end

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> gie_i); // R6
  AST_FLAG_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_flag |-> (rdata_o[7:NGRP] == '0)); // R2
endmodule

// File: tb/tb_pcint_ctrl.sv
`timescale 1ns/1ps
module tb_pcint_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [11:0] pins_i = '0;
  logic [1:0]  ack_i = '0;
  logic        gie_i = 1'b0;
  logic [1:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  pcint_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .pins_i(pins_i), .ack_i(ack_i),
    .gie_i(gie_i), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #0.5 d = rdata_o;
  endtask

  task automatic toggle(int p);
    @(negedge clk_i);
    pins_i[p] = ~pins_i[p];
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(8'h0F, v); chk("R1 mask_lo", v, 8'h00);
    rd(8'h10, v); chk("R1 mask_hi", v, 8'h00);
    rd(8'h11, v); chk("R1 flags", v, 8'h00);
    rd(8'h12, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", {6'd0, irq_o}, 8'h00);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    wr(8'h0F, 8'hA5); rd(8'h0F, v); chk("R2 mask_lo rw", v, 8'hA5);
    wr(8'h10, 8'hFF); rd(8'h10, v); chk("R2 mask_hi width", v, 8'h0F);
    wr(8'h12, 8'hFF); rd(8'h12, v); chk("R2 ctrl width", v, 8'h03);
    wr(8'h11, 8'hFF); rd(8'h11, v); chk("R2 flags w1 on clear", v, 8'h00);
    rd(8'h13, v); chk("R2 unmapped 13", v, 8'h00);
    rd(8'h00, v); chk("R2 unmapped 00", v, 8'h00);
    wr(8'h0F, 8'h00); wr(8'h10, 8'h00); wr(8'h12, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    wr(8'h0F, 8'h08);
    toggle(3); rd(8'h11, v); chk("R3 rising edge", v, 8'h01);
    chk("R5 no irq when disabled", {6'd0, irq_o}, 8'h00);
    wr(8'h11, 8'h01); rd(8'h11, v); chk("R7 cleared", v, 8'h00);
    toggle(3); rd(8'h11, v); chk("R3 falling edge", v, 8'h01);
    chk("R5 flag set while ctrl=0", v, 8'h01);
    wr(8'h11, 8'h01);
  endtask

  task automatic t_masked();
    logic [7:0] v;
    wr(8'h0F, 8'h08); wr(8'h10, 8'h01);
    toggle(5); rd(8'h11, v); chk("R4 masked lower pin", v, 8'h00);
    toggle(9); rd(8'h11, v); chk("R4 masked upper pin", v, 8'h00);
    toggle(5); toggle(9); rd(8'h11, v); chk("R4 masked back edges", v, 8'h00);
  endtask

  task automatic t_groups();
    logic [7:0] v;
    toggle(8); rd(8'h11, v); chk("R10 upper only", v, 8'h02);
    wr(8'h11, 8'h02);
    toggle(3); rd(8'h11, v); chk("R10 lower only", v, 8'h01);
    wr(8'h11, 8'h01);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    toggle(3);
    for (int c = 0; c < 8; c++) begin
      wr(8'h12, {6'd0, c[1:0]});
      @(negedge clk_i); gie_i = c[2];
      #0.5 chk("R6 irq gating", {6'd0, irq_o}, {7'd0, c[0] & c[2]});
    end
    gie_i = 1'b0; wr(8'h12, 8'h00);
    wr(8'h11, 8'h01); rd(8'h11, v); chk("R6 cleanup", v, 8'h00);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    toggle(3); toggle(8);
    wr(8'h11, 8'h00); rd(8'h11, v); chk("R7 write zero keeps", v, 8'h03);
    wr(8'h11, 8'h02); rd(8'h11, v); chk("R7 clear upper only", v, 8'h01);
    wr(8'h11, 8'h01); rd(8'h11, v); chk("R7 clear lower", v, 8'h00);
  endtask

  task automatic t_ack();
    logic [7:0] v;
    toggle(3); toggle(8);
    @(negedge clk_i); ack_i = 2'b01;
    @(negedge clk_i); ack_i = 2'b00;
    rd(8'h11, v); chk("R8 ack lower", v, 8'h02);
    @(negedge clk_i); ack_i = 2'b10;
    @(negedge clk_i); ack_i = 2'b00;
    rd(8'h11, v); chk("R8 ack upper", v, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    toggle(3);
    // event reaches the flag on the third edge after the pin change
    @(negedge clk_i); pins_i[3] = ~pins_i[3];
    @(negedge clk_i);
    @(negedge clk_i); ack_i = 2'b01;
    @(negedge clk_i); ack_i = 2'b00;
    rd(8'h11, v); chk("R9 set beats ack", v, 8'h01);
    @(negedge clk_i); pins_i[3] = ~pins_i[3];
    @(negedge clk_i);
    @(negedge clk_i); addr_i = 8'h11; wdata_i = 8'h01; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
    rd(8'h11, v); chk("R9 set beats w1c", v, 8'h01);
    wr(8'h11, 8'h01); rd(8'h11, v); chk("R9 plain clear", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_regmap();
    t_edges();
    t_masked();
    t_groups();
    t_irq();
    t_w1c();
    t_ack();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule